// File: doc/BRIEF.md
# Pattern-Driven Memory Loopback Tester

This block exercises a 256-word by 9-bit two-port RAM with no outside stimulus. A write-side counter walks the address space one step per clock. At each address a small constant table gives two things: a write-enable bit and an 8-bit offset. The RAM stores the address plus that offset. A read-side counter walks the same RAM at one third of the write rate. The read data is not registered after the array, and it drives nine indicator outputs.

Both sides run from one reference clock. The read side advances on a divide-by-three enable, so every cycle of the loop is deterministic. The write and read addresses and the write data are also brought out so that the loop can be watched from outside. An asynchronous active-low reset is released through a synchronizer. It restarts both counters and leaves the RAM contents as they are.

Top module: `memtest_loop`

## Requirements
- R1: While `rst_n` is low, and for two clocks after it rises, `wr_addr` and `rd_addr` are 0 and `wr_en` is 0. On the third rising clock edge after release, `wr_addr` becomes 1.
- R2: Once running, `wr_addr` increases by one on every clock and wraps from 255 to 0.
- R3: The write enable is taken from bit 8 of the table word at the current write address. It is 1 for addresses 0–63 and 128–191 and 0 for addresses 64–127 and 192–255. It is always 0 while the loop is held in reset.
- R4: `wr_data` equals `wr_addr` plus the table offset in bits 7:0, as a 9-bit sum without wrap. The offset is 66 for addresses 0–127, 67 for 128–191 and 0 for 192–255. For example, address 36 gives 102.
- R5: A clock edge with `wr_en` high stores `wr_data` at `wr_addr`. Addresses written with the enable low keep their earlier content.
- R6: Once running, `rd_addr` advances by one on every third clock, counted from release, and wraps from 255 to 0. It holds on the two clocks between steps.
- R7: `led` shows the current RAM content at the read address that was present before the most recent read step. This is a latency of one read step, and there is no output register.
- R8: Asserting `rst_n` in the middle of a run returns both counters and the read phase to their start values. The RAM keeps its content, so `led` shows the stored word at address 0 straight away.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock for both sides |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_addr | output | 8 | Current write address |
| wr_en | output | 1 | Write strobe applied to the RAM this cycle |
| wr_data | output | 9 | Word written when `wr_en` is high |
| rd_addr | output | 8 | Current read address |
| led | output | 9 | Unregistered RAM read data |

## Verification
A write counter that skips a step, or a table entry that is wrong, shows up on `wr_addr`, `wr_en` or `wr_data` in the same cycle. A divider that slips its phase moves `rd_addr` off its three-clock cadence at the very next read step. A wrong word stored in the RAM, or an error in the read latch, shows on `led` only when the read side reaches that address. This can be up to a full read pass of 768 clocks later. A reset that clears the array is exposed by the stored value at address 0, which must appear on `led` right after a mid-run reset.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

  localparam int ADDR_W_DEF = 8;
  localparam int DATA_W_DEF = 9;
  localparam int OFF_W_DEF  = 8;
  localparam int RD_DIV_DEF = 3;
  localparam int SYNC_DEF   = 2;

  localparam int OFFSET_LOW  = 66;
  localparam int OFFSET_HIGH = 67;

  typedef struct packed {
    logic       we;
    logic [7:0] off;
  } pat_word_t;

  // Pattern by address quarter: 0 write/66, 1 hold/66, 2 write/67, 3 hold/0
  function automatic pat_word_t pattern_for_quarter(input logic [1:0] qtr);
    pat_word_t w;
    unique case (qtr)
      2'd0:    begin w.we = 1'b1; w.off = 8'(OFFSET_LOW);  end
      2'd1:    begin w.we = 1'b0; w.off = 8'(OFFSET_LOW);  end
      2'd2:    begin w.we = 1'b1; w.off = 8'(OFFSET_HIGH); end
      default: begin w.we = 1'b0; w.off = 8'd0;            end
    endcase
    return w;
  endfunction

endpackage

// File: rtl/memtest_rst_sync.sv
module memtest_rst_sync #(
  parameter int STAGES = memtest_pkg::SYNC_DEF
) (
  input  logic clk,
  input  logic rst_n,
  output logic run
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nx;

  always_comb begin
    sync_nx = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_nx;
  end

  assign run = sync_q[STAGES-1];

endmodule

// File: rtl/memtest_wr_gen.sv
module memtest_wr_gen #(
  parameter int ADDR_W = memtest_pkg::ADDR_W_DEF,
  parameter int DATA_W = memtest_pkg::DATA_W_DEF,
  parameter int OFF_W  = memtest_pkg::OFF_W_DEF
) (
  input  logic              clk,
  input  logic              run,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data
);
  import memtest_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_nx;
  logic [DATA_W-1:0] table_q [DEPTH];
  logic [DATA_W-1:0] word;

  // Pattern table, one constant word per address
  for (genvar i = 0; i < DEPTH; i++) begin : g_table
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
    pat_word_t pw;
    assign pw = pattern_for_quarter(IDX[ADDR_W-1 -: 2]);
    assign table_q[i] = {pw.we, DATA_W'(pw.off)} [DATA_W-1:0] | {pw.we, {(DATA_W-1){1'b0}}};
  end

  always_comb begin
    addr_nx = addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge run) begin
    if (!run) addr_q <= '0;
    else      addr_q <= addr_nx;
  end

  always_comb begin
    word    = table_q[addr_q];
    wr_en   = run & word[DATA_W-1];
    wr_data = DATA_W'(addr_q) + DATA_W'(word[OFF_W-1:0]);
  end

  assign wr_addr = addr_q;

endmodule

// File: rtl/memtest_rd_seq.sv
module memtest_rd_seq #(
  parameter int ADDR_W = memtest_pkg::ADDR_W_DEF,
  parameter int DIV    = memtest_pkg::RD_DIV_DEF
) (
  input  logic              clk,
  input  logic              run,
  output logic              tick,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] lat_addr
);

  localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

  logic [PH_W-1:0]   ph_q,  ph_nx;
  logic [ADDR_W-1:0] rd_q,  rd_nx;
  logic [ADDR_W-1:0] lat_q, lat_nx;

  always_comb begin
    tick   = run && (ph_q == PH_LAST);
    ph_nx  = tick ? '0 : ph_q + 1'b1;
    rd_nx  = tick ? rd_q + 1'b1 : rd_q;
    lat_nx = tick ? rd_q : lat_q;
  end

  always_ff @(posedge clk or negedge run) begin
    if (!run) begin
      ph_q  <= '0;
      rd_q  <= '0;
      lat_q <= '0;
    end else begin
      ph_q  <= ph_nx;
      rd_q  <= rd_nx;
      lat_q <= lat_nx;
    end
  end

  assign rd_addr  = rd_q;
  assign lat_addr = lat_q;

endmodule

// File: rtl/memtest_dpram.sv
module memtest_dpram #(
  parameter int ADDR_W = memtest_pkg::ADDR_W_DEF,
  parameter int DATA_W = memtest_pkg::DATA_W_DEF
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/memtest_loop.sv
module memtest_loop #(
  parameter int ADDR_W = memtest_pkg::ADDR_W_DEF,
  parameter int DATA_W = memtest_pkg::DATA_W_DEF,
  parameter int OFF_W  = memtest_pkg::OFF_W_DEF,
  parameter int RD_DIV = memtest_pkg::RD_DIV_DEF,
  parameter int SYNC_N = memtest_pkg::SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] led
);

  logic              run;
  logic              rd_tick;
  logic [ADDR_W-1:0] lat_addr;

  memtest_rst_sync #(.STAGES(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run)
  );

  memtest_wr_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_wr (
    .clk     (clk),
    .run     (run),
    .wr_addr (wr_addr),
    .wr_en   (wr_en),
    .wr_data (wr_data)
  );

  memtest_rd_seq #(.ADDR_W(ADDR_W), .DIV(RD_DIV)) u_rd (
    .clk      (clk),
    .run      (run),
    .tick     (rd_tick),
    .rd_addr  (rd_addr),
    .lat_addr (lat_addr)
  );

  memtest_dpram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .wclk  (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (lat_addr),
    .rdata (led)
  );

endmodule

// File: rtl/memtest_chk.sv
module memtest_chk #(
  parameter int ADDR_W = memtest_pkg::ADDR_W_DEF,
  parameter int DATA_W = memtest_pkg::DATA_W_DEF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              tick,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] rd_addr
);

  logic [DATA_W-1:0] delta;
  assign delta = wr_data - DATA_W'(wr_addr);

  // R1
  reset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (wr_addr == '0 && rd_addr == '0));

  // R2
  wr_step_chk: assert property (@(posedge clk) disable iff (!run)
    $past(run) |-> (wr_addr == $past(wr_addr) + 1'b1));

  // R3
  wr_en_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (run && !wr_addr[ADDR_W-2]));

  // R4
  wr_data_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (delta == '0 || delta == DATA_W'(memtest_pkg::OFFSET_LOW)
             || delta == DATA_W'(memtest_pkg::OFFSET_HIGH)));

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!run)
    !tick |=> $stable(rd_addr));

  // R6
  rd_step_chk: assert property (@(posedge clk) disable iff (!run)
    tick |=> (rd_addr == $past(rd_addr) + 1'b1));

  // R6
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!run)
    tick |=> !tick);

endmodule

bind memtest_loop memtest_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .run     (run),
  .tick    (rd_tick),
  .wr_addr (wr_addr),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_addr (rd_addr)
);

// File: tb/tb_memtest_loop.sv
`timescale 1ns/1ps
module tb_memtest_loop;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] wr_addr;
  logic       wr_en;
  logic [8:0] wr_data;
  logic [7:0] rd_addr;
  logic [8:0] led;

  memtest_loop dut (
    .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_addr(rd_addr), .led(led)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit chk_on = 0;
  bit phase2 = 0;
  bit finished = 0;

  // behavioural reference state
  int s0 = 0, s1 = 0;
  int wa = 0, ra = 0, ph = 0, lat = 0;
  int shadow [256];
  bit valid  [256];
  int cyc_run = 0;

  function automatic bit pat_en(int a);
    return (a < 64) || (a >= 128 && a < 192);
  endfunction

  function automatic int pat_off(int a);
    if (a < 128) return 66;
    if (a < 192) return 67;
    return 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      s0 = 0; s1 = 0; wa = 0; ra = 0; ph = 0; lat = 0; cyc_run = 0;
    end else begin
      int old_run;
      old_run = s1;
      s1 = s0;
      s0 = 1;
      if (old_run != 0) begin
        if (pat_en(wa)) begin
          shadow[wa] = wa + pat_off(wa);
          valid[wa]  = 1'b1;
        end
        wa = (wa + 1) % 256;
        if (ph == 2) begin
          lat = ra; ra = (ra + 1) % 256; ph = 0;
        end else ph++;
        cyc_run++;
      end
    end
    chk_on = 1'b1;
  end

  always @(negedge clk) begin
    if (chk_on && !finished) begin
      if (s1 == 0) begin
        // R1: held at start values during reset and synchronizer latency
        check(wr_addr == 0, "R1 wr_addr", int'(wr_addr), 0);
        check(rd_addr == 0, "R1 rd_addr", int'(rd_addr), 0);
        check(wr_en == 1'b0, "R1 wr_en", int'(wr_en), 0);
      end else begin
        check(wr_addr == 8'(wa), "R2 wr_addr", int'(wr_addr), wa);
        check(wr_en == pat_en(wa), "R3 wr_en", int'(wr_en), int'(pat_en(wa)));
        check(wr_data == 9'(wa + pat_off(wa)), "R4 wr_data", int'(wr_data), wa + pat_off(wa));
        check(rd_addr == 8'(ra), "R6 rd_addr", int'(rd_addr), ra);
        if (wa == 36)
          check(wr_data == 9'd102, "R4 example addr 36", int'(wr_data), 102);
        if (cyc_run == 1)
          check(wr_addr == 8'd1, "R1 first step after release", int'(wr_addr), 1);
      end
      if (valid[lat]) begin
        if (phase2)
          check(led == 9'(shadow[lat]), "R8 R7 led after mid-run reset", int'(led), shadow[lat]);
        else
          check(led == 9'(shadow[lat]), "R5 R7 led", int'(led), shadow[lat]);
        if (lat == 36 && s1 != 0)
          check(led == 9'd102, "R7 example read 36", int'(led), 102);
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin shadow[i] = 0; valid[i] = 1'b0; end
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (1100) @(negedge clk);
    #1 rst_n = 1'b0;
    phase2 = 1'b1;
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (1000) @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule